// File: doc/BRIEF.md
# Bus-Matching FIFO Read Unpacker

This block sits between the 36-bit storage array of a FIFO and a read port whose width is fixed at reset. The output can take each stored long-word whole, as two 18-bit halves, or as four 9-bit bytes. When the port is narrower than the stored word, each long-word popped from storage is held locally. It is then handed out one piece per read, in the byte order that was chosen at reset.

The storage side has a "data available" flag, the data at the head of storage, and a pop strobe driven by this block. A new long-word is popped only when a read arrives and nothing remains of the current one. The block signals that a long-word has been used up in the same cycle as the read that takes its last piece. The FIFO core uses that strobe to move its empty and almost-empty flags.

Width code and byte order are sampled on every clock while reset is high. They are frozen from the first clock with reset low and stay fixed until the next reset.

Top module: `bm_read_unpacker`

## Requirements
- R1: While reset is high and after it is released, `rd_data` is all zero until the first accepted read, and no long-word is held.
- R2: In long-word mode (width code 2'b00), every accepted read pops one stored word, and `rd_data` shows that whole 36-bit word from the clock after the read edge.
- R3: In half mode (width code 2'b01) with big order (`cfg_big` high), the first read of a long-word presents bits 35:18 on `rd_data[17:0]` and the second read presents bits 17:0. `rd_data[35:18]` is zero.
- R4: In half mode with little order (`cfg_big` low), bits 17:0 come first and bits 35:18 come second, again on `rd_data[17:0]`, with the upper bits zero.
- R5: In byte mode (width code 2'b10) with big order, the four reads of a long-word present bits 35:27, 26:18, 17:9 and 8:0, in that sequence, on `rd_data[8:0]`. All higher bits are zero.
- R6: In byte mode with little order, the sequence is bits 8:0, 17:9, 26:18, 35:27.
- R7: `st_pop` is high only in a cycle where `rd_en` is high, no piece of the current long-word remains, and `st_valid` is high. No pop occurs while pieces remain.
- R8: `lw_done` is high, combinationally with `rd_en`, exactly in the cycle of the read that takes the last piece of a long-word (every read in long-word mode).
- R9: `rd_empty` is high when no piece remains and `st_valid` is low. A read while `rd_empty` is high leaves `rd_data` unchanged, pops nothing and does not raise `lw_done`.
- R10: Width code and order are taken from the inputs while reset is high. Changes on those inputs after reset is released have no effect.
- R11: Width code 2'b11 behaves as long-word mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high master reset; configuration is sampled while high |
| cfg_width | input | 2 | Port width code: 00 long-word, 01 half, 10 byte, 11 long-word |
| cfg_big | input | 1 | High: most significant piece first; low: least significant first |
| st_valid | input | 1 | Storage holds at least one long-word |
| st_data | input | 36 | Long-word at the head of storage |
| st_pop | output | 1 | Pop the head long-word at this clock edge |
| rd_en | input | 1 | Read request from the output port |
| rd_data | output | 36 | Registered output piece, zero-extended when narrow |
| rd_empty | output | 1 | Nothing left to read |
| lw_done | output | 1 | This read consumes the last piece of a long-word |

## Verification
In long-word mode, fetching a new word from storage and completing a long-word happen in the same cycle. The bench drives back-to-back reads in that mode and requires both `st_pop` and `lw_done` high before the edge, then the popped word on `rd_data` after it. In the narrow modes the two events fall in different cycles. The bench reads the middle pieces of a word while storage still holds a further word, and requires that no pop occurs and that the storage head does not move until the last piece has been read.

// File: rtl/bm_unpack_pkg.sv
package bm_unpack_pkg;

    typedef enum logic [1:0] {
        PW_LONG = 2'b00,
        PW_HALF = 2'b01,
        PW_BYTE = 2'b10
    } pw_mode_e;

    typedef struct packed {
        pw_mode_e mode;
        logic     big;
    } unpack_cfg_t;

    localparam int MAX_PIECES = 4;
    localparam int CNT_W      = $clog2(MAX_PIECES + 1);
    localparam int IDX_W      = $clog2(MAX_PIECES);

    function automatic pw_mode_e decode_width(input logic [1:0] code);
        case (code)
            2'b01:   return PW_HALF;
            2'b10:   return PW_BYTE;
            default: return PW_LONG;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] pieces_of(input pw_mode_e m);
        case (m)
            PW_HALF: return CNT_W'(2);
            PW_BYTE: return CNT_W'(4);
            default: return CNT_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/bm_unpack_cfg.sv
module bm_unpack_cfg
    import bm_unpack_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  cfg_width,
    input  logic        cfg_big,
    output unpack_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.mode <= decode_width(cfg_width);
            cfg_q.big  <= cfg_big;
        end
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(cfg_q)) else $error("config moved outside reset"); // R10

endmodule

// File: rtl/bm_unpack_lane_sel.sv
module bm_unpack_lane_sel
    import bm_unpack_pkg::*;
#(
    parameter int LW_W = 36
) (
    input  logic [LW_W-1:0]  word,
    input  unpack_cfg_t      cfg,
    input  logic [IDX_W-1:0] k,
    output logic [LW_W-1:0]  piece
);

    localparam int HW = LW_W / 2;
    localparam int QW = LW_W / 4;

    logic [HW-1:0] halves [2];
    logic [QW-1:0] bytes  [MAX_PIECES];

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_half
            assign halves[g] = word[g*HW +: HW];
        end
        for (g = 0; g < MAX_PIECES; g++) begin : g_byte
            assign bytes[g] = word[g*QW +: QW];
        end
    endgenerate

    logic [CNT_W-1:0] last_idx;
    logic [IDX_W-1:0] lane;

    always_comb begin
        last_idx = pieces_of(cfg.mode) - CNT_W'(1);
        lane     = cfg.big ? IDX_W'(last_idx - CNT_W'(k)) : k;
        piece    = '0;
        case (cfg.mode)
            PW_HALF: piece[HW-1:0] = halves[lane[0]];
            PW_BYTE: piece[QW-1:0] = bytes[lane];
            default: piece         = word;
        endcase
    end

endmodule

// File: rtl/bm_unpack_seq.sv
module bm_unpack_seq
    import bm_unpack_pkg::*;
#(
    parameter int LW_W = 36
) (
    input  logic             clk,
    input  logic             rst,
    input  unpack_cfg_t      cfg,
    input  logic             rd_en,
    input  logic             st_valid,
    input  logic [LW_W-1:0]  st_data,
    input  logic [LW_W-1:0]  piece,
    output logic [LW_W-1:0]  sel_word,
    output logic [IDX_W-1:0] k,
    output logic             st_pop,
    output logic             lw_done,
    output logic             rd_empty,
    output logic [LW_W-1:0]  rd_data
);

    logic [LW_W-1:0]  hold_q;
    logic [CNT_W-1:0] rem_q;
    logic [CNT_W-1:0] n_pieces;
    logic [CNT_W-1:0] k_full;
    logic             drained;
    logic             take;
    logic             last;

    always_comb begin
        n_pieces = pieces_of(cfg.mode);
        drained  = (rem_q == '0);
        sel_word = drained ? st_data : hold_q;
        k_full   = drained ? '0 : (n_pieces - rem_q);
        k        = IDX_W'(k_full);
        take     = rd_en && (!drained || st_valid);
        st_pop   = rd_en && drained && st_valid;
        last     = drained ? (n_pieces == CNT_W'(1)) : (rem_q == CNT_W'(1));
        lw_done  = take && last;
        rd_empty = drained && !st_valid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            rem_q   <= '0;
            rd_data <= '0;
        end else if (take) begin
            rd_data <= piece;
            if (drained) begin
                hold_q <= st_data;
                rem_q  <= n_pieces - CNT_W'(1);
            end else begin
                rem_q  <= rem_q - CNT_W'(1);
            end
        end
    end

    AST_DONE_DRAINS: assert property (@(posedge clk) disable iff (rst)
        lw_done |=> (rem_q == '0)) else $error("pieces left after last read"); // R8

    AST_REM_BOUND: assert property (@(posedge clk) disable iff (rst)
        rem_q < n_pieces) else $error("remaining count out of range"); // R7

    AST_EMPTY_READ_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (rd_empty && rd_en) |=> $stable(rd_data)) else $error("empty read changed data"); // R9

endmodule

// File: rtl/bm_read_unpacker.sv
module bm_read_unpacker
    import bm_unpack_pkg::*;
#(
    parameter int LW_W = 36
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      cfg_width,
    input  logic            cfg_big,
    input  logic            st_valid,
    input  logic [LW_W-1:0] st_data,
    output logic            st_pop,
    input  logic            rd_en,
    output logic [LW_W-1:0] rd_data,
    output logic            rd_empty,
    output logic            lw_done
);

    localparam int HW = LW_W / 2;
    localparam int QW = LW_W / 4;

    unpack_cfg_t      cfg;
    logic [LW_W-1:0]  sel_word;
    logic [LW_W-1:0]  piece;
    logic [IDX_W-1:0] k;

    bm_unpack_cfg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_width (cfg_width),
        .cfg_big   (cfg_big),
        .cfg_q     (cfg)
    );

    bm_unpack_lane_sel #(.LW_W(LW_W)) u_lane (
        .word  (sel_word),
        .cfg   (cfg),
        .k     (k),
        .piece (piece)
    );

    bm_unpack_seq #(.LW_W(LW_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg),
        .rd_en    (rd_en),
        .st_valid (st_valid),
        .st_data  (st_data),
        .piece    (piece),
        .sel_word (sel_word),
        .k        (k),
        .st_pop   (st_pop),
        .lw_done  (lw_done),
        .rd_empty (rd_empty),
        .rd_data  (rd_data)
    );

    AST_LONG_PASS: assert property (@(posedge clk) disable iff (rst)
        (st_pop && cfg.mode == PW_LONG) |=> (rd_data == $past(st_data))) else $error("long-word not passed whole"); // R2

    AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == PW_HALF) |-> (rd_data[LW_W-1:HW] == '0)) else $error("half mode upper bits set"); // R3

    AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == PW_BYTE) |-> (rd_data[LW_W-1:QW] == '0)) else $error("byte mode upper bits set"); // R5

    AST_POP_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
        st_pop |-> (rd_en && st_valid)) else $error("pop without read"); // R7

endmodule

// File: tb/bm_read_unpacker_tb.sv
module bm_read_unpacker_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_width = 2'b00;
    logic        cfg_big = 1'b1;
    logic        rd_en = 1'b0;
    logic        st_pop;
    logic [35:0] rd_data;
    logic        rd_empty;
    logic        lw_done;

    logic [35:0] mem [32];
    int          head = 0;
    int          count = 0;
    logic        q_clr = 1'b0;
    logic        st_valid;
    logic [35:0] st_data;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #5 clk = ~clk;

    assign st_valid = (head < count);
    assign st_data  = st_valid ? mem[head] : 36'h0;

    always @(posedge clk) begin
        if (q_clr) head <= 0;
        else if (st_pop) head <= head + 1;
    end

    bm_read_unpacker dut_i (
        .clk(clk), .rst(rst), .cfg_width(cfg_width), .cfg_big(cfg_big),
        .st_valid(st_valid), .st_data(st_data), .st_pop(st_pop),
        .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty), .lw_done(lw_done)
    );

    task automatic check(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Independent model of the piece order: m 0 long, 1 half, 2 byte
    function automatic logic [35:0] ref_piece(input logic [35:0] w, input int m, input bit big, input int k);
        int idx;
        if (m == 0) return w;
        if (m == 1) begin
            idx = big ? 1 - k : k;
            return (idx == 1) ? {18'h0, w[35:18]} : {18'h0, w[17:0]};
        end
        idx = big ? 3 - k : k;
        case (idx)
            0: return {27'h0, w[8:0]};
            1: return {27'h0, w[17:9]};
            2: return {27'h0, w[26:18]};
            default: return {27'h0, w[35:27]};
        endcase
    endfunction

    task automatic do_reset(input logic [1:0] code, input bit big);
        @(negedge clk);
        rst = 1'b1; q_clr = 1'b1; rd_en = 1'b0;
        cfg_width = code; cfg_big = big;
        count = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0; q_clr = 1'b0;
    endtask

    task automatic push(input logic [35:0] w);
        mem[count] = w;
        count++;
    endtask

    task automatic rd_piece(input logic [35:0] exp, input bit exp_done, input string req);
        @(negedge clk);
        rd_en = 1'b1;
        #1;
        check(lw_done == exp_done, {req, " lw_done"}, 36'(lw_done), 36'(exp_done));
        @(negedge clk);
        rd_en = 1'b0;
        check(rd_data == exp, {req, " rd_data"}, rd_data, exp);
    endtask

    task automatic t_reset();
        do_reset(2'b00, 1'b1);
        @(negedge clk);
        check(rd_data == 36'h0, "R1 data zero", rd_data, 36'h0);
        check(rd_empty == 1'b1, "R1 empty", 36'(rd_empty), 36'h1);
        check(st_pop == 1'b0, "R1 no pop", 36'(st_pop), 36'h0);
    endtask

    task automatic t_long();
        logic [35:0] w [3];
        w[0] = 36'h9_8765_4321; w[1] = 36'hF_0F0F_0F0F; w[2] = 36'h1_2345_6789;
        do_reset(2'b00, 1'b0);
        for (int i = 0; i < 3; i++) push(w[i]);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            rd_en = 1'b1;
            #1;
            check(st_pop && lw_done, "R2 pop and done same cycle", {34'h0, st_pop, lw_done}, 36'h3); // R8
            @(negedge clk);
            rd_en = 1'b0;
            check(rd_data == w[i], "R2 whole word", rd_data, w[i]);
        end
        check(rd_empty == 1'b1, "R9 empty after drain", 36'(rd_empty), 36'h1);
    endtask

    task automatic t_half(input bit big);
        logic [35:0] w [2];
        string req;
        w[0] = 36'hA_BCDE_1234; w[1] = 36'h5_5AA5_0FF1;
        req = big ? "R3" : "R4";
        do_reset(2'b01, big);
        push(w[0]); push(w[1]);
        for (int i = 0; i < 2; i++)
            for (int k = 0; k < 2; k++)
                rd_piece(ref_piece(w[i], 1, big, k), k == 1, req);
    endtask

    task automatic t_byte(input bit big);
        logic [35:0] w;
        string req;
        w = 36'hC_3A5F_9E17;
        req = big ? "R5" : "R6";
        do_reset(2'b10, big);
        push(w);
        for (int k = 0; k < 4; k++)
            rd_piece(ref_piece(w, 2, big, k), k == 3, req);
    endtask

    task automatic t_no_midword_pop();
        logic [35:0] w0, w1;
        w0 = 36'h1_1111_2222; w1 = 36'h3_3333_4444;
        do_reset(2'b10, 1'b1);
        push(w0); push(w1);
        rd_piece(ref_piece(w0, 2, 1, 0), 0, "R7");
        check(head == 1, "R7 one pop after first piece", 36'(head), 36'h1);
        @(negedge clk);
        rd_en = 1'b1;
        #1;
        check(st_pop == 1'b0, "R7 no pop mid-word", 36'(st_pop), 36'h0);
        @(negedge clk);
        rd_en = 1'b0;
        check(head == 1, "R7 head unmoved", 36'(head), 36'h1);
        rd_piece(ref_piece(w0, 2, 1, 2), 0, "R7");
        rd_piece(ref_piece(w0, 2, 1, 3), 1, "R7");
        rd_piece(ref_piece(w1, 2, 1, 0), 0, "R7 next word");
        check(head == 2, "R7 second pop", 36'(head), 36'h2);
    endtask

    task automatic t_empty();
        logic [35:0] w;
        w = 36'h7_6543_210F;
        do_reset(2'b01, 1'b1);
        push(w);
        rd_piece(ref_piece(w, 1, 1, 0), 0, "R9");
        check(rd_empty == 1'b0, "R9 piece still pending", 36'(rd_empty), 36'h0);
        rd_piece(ref_piece(w, 1, 1, 1), 1, "R9");
        check(rd_empty == 1'b1, "R9 empty", 36'(rd_empty), 36'h1);
        @(negedge clk);
        rd_en = 1'b1;
        #1;
        check(st_pop == 1'b0 && lw_done == 1'b0, "R9 empty read inert", {34'h0, st_pop, lw_done}, 36'h0);
        @(negedge clk);
        rd_en = 1'b0;
        check(rd_data == ref_piece(w, 1, 1, 1), "R9 data held", rd_data, ref_piece(w, 1, 1, 1));
    endtask

    task automatic t_cfg_ignored();
        logic [35:0] w;
        w = 36'h8_1234_ABCD;
        do_reset(2'b10, 1'b1);
        @(negedge clk);
        cfg_width = 2'b00; cfg_big = 1'b0;
        push(w);
        rd_piece(ref_piece(w, 2, 1, 0), 0, "R10");
        rd_piece(ref_piece(w, 2, 1, 1), 0, "R10");
    endtask

    task automatic t_code11();
        logic [35:0] w;
        w = 36'hE_DCBA_9876;
        do_reset(2'b11, 1'b1);
        push(w);
        rd_piece(w, 1, "R11");
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_long();
        t_half(1'b1);
        t_half(1'b0);
        t_byte(1'b1);
        t_byte(1'b0);
        t_no_midword_pop();
        t_empty();
        t_cfg_ignored();
        t_code11();
        finish_run();
    end

    initial begin
        #1_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 36'h1, 36'h0);
        finish_run();
    end

endmodule